// File: doc/BRIEF.md
# SPI Master/Slave Port with Mode-Fault Detection

This block is a byte-wide serial peripheral port that acts either as the clock-driving master or as a selected slave. Software drives it through three byte registers on a small register-access bus: data at address 0, control at address 1 and status at address 2. In master mode a data write loads the shifter and launches one eight-bit exchange at once. SCK comes from the internal clock through a four-way divider. In slave mode the same shifter moves on the edges of an external SCK while the active-low select is low. A data write in slave mode only stages the byte that the next exchange will return. A received byte is copied into a holding buffer at the end of the byte. Reads of address 0 return that buffer and never the live shifter.

Control bits, MSB to LSB: bit 7 interrupt enable, bit 6 pin output enable, bit 5 interrupt-source select, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate. The shift engine has three states. `ST_IDLE` moves to `ST_MASTER` on a data write in master mode, and to `ST_SLAVE` when slave mode is set and select is low. `ST_MASTER` returns to `ST_IDLE` after the sixteenth SCK edge or on a mode fault. `ST_SLAVE` returns to `ST_IDLE` when select goes high or master mode is set. A master that sees its select pin pulled low drops out of master mode, turns off its pin drivers and sets a mode-fault flag. The interrupt line is high when interrupts are enabled and exactly one of the two flags is set.

Top module: `spi_port`

## Requirements
- R1: After reset, control, data buffer and status all read 00h. SCK output is low, all three output enables are 0 and the interrupt is low.
- R2: In master mode a data write shifts the byte out on MOSI MSB first while eight bits are shifted in from MISO, over 16 SCK edges. Status bit 7 (transfer complete) then reads 1 and address 0 returns the received byte.
- R3: SCK rests at the control bit 3 level before and after every master byte. With control bit 2 at 0, data is captured on odd SCK edges (1st, 3rd, ...) and launched on even edges. With bit 2 at 1, this is reversed.
- R4: In master mode, rate codes 00, 01, 10 and 11 give SCK half periods of 1, 2, 8 and 16 internal clocks (divide by 2, 4, 16, 32).
- R5: A data write while a master byte is in progress has no effect: the running byte is unchanged and no further SCK edges follow it.
- R6: In slave mode with select low, the block captures MOSI and launches the staged byte on MISO on external SCK edges under the same phase rules. After 16 edges it sets transfer complete and buffers the received byte.
- R7: While select is high, a slave ignores SCK edges (transfer complete stays 0) and keeps the MISO enable at 0.
- R8: Select low while the master bit is 1 clears control bits 4 and 6, sets status bit 6 (mode fault) and aborts any master byte.
- R9: With output enable set, a master enables SCK and MOSI and disables MISO. A selected slave enables only MISO. With output enable clear, all enables are 0.
- R10: The interrupt is high only when interrupt enable is 1 and exactly one of transfer complete and mode fault is 1. The source-select bit is presented on its own output.
- R11: A status read followed later by a data-register access clears transfer complete. A data read with no prior status read leaves it set. A status read followed by a control write clears mode fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the flag-clear sequences) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Serial clock pin driver enable |
| mosi_i | input | 1 | Master-out data from the pin (slave) |
| mosi_o | output | 1 | Master-out data to the pin |
| mosi_oe | output | 1 | Master-out pin driver enable |
| miso_i | input | 1 | Master-in data from the pin (master) |
| miso_o | output | 1 | Master-in data to the pin |
| miso_oe | output | 1 | Master-in pin driver enable |
| ss_n_i | input | 1 | Active-low slave select |
| irq_o | output | 1 | Interrupt request |
| irq_sel_o | output | 1 | Interrupt-source select bit for the interrupt controller |

## Verification
The hardest state to reach is the one where both flags are set together, because the interrupt must then fall even though each flag alone would raise it. The stimulus gets there by finishing a master byte with interrupts enabled and leaving transfer complete uncleared. It then pulls select low so that a mode fault lands on top of it. After that, the two clear sequences are run one at a time, so the interrupt is seen to rise again and then fall. A behavioural slave follows SCK at every phase and rate, feeds MISO and scores each MOSI byte against a queue. This exposes wrong edge choice, wrong bit order or an extra byte.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASTER = 2'd1,
        ST_SLAVE  = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic       irq_en;
        logic       out_en;
        logic       irq_src;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    // SCK half period in internal clocks for each rate code
    function automatic int unsigned half_cycles(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/spi_port_sync.sv
`timescale 1ns/1ps
module spi_port_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_port_clkgen.sv
`timescale 1ns/1ps
module spi_port_clkgen
    import spi_port_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'(half_cycles(rate) - 1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!run || tick)      cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_port_shift.sv
`timescale 1ns/1ps
module spi_port_shift
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          abort,
    input  logic          slave_sel,
    input  logic          cpha,
    input  logic          tick,
    input  logic          sck_edge,
    input  logic          din,
    output logic          out_bit,
    output logic          sck_lvl,
    output logic          m_busy,
    output logic          done,
    output logic [DW-1:0] rx_data
);
    localparam int EDGES = 2 * DW;
    localparam int CW    = $clog2(EDGES);

    xfer_state_t   state, nxt;
    logic [CW-1:0] edge_cnt;
    logic [DW-1:0] sreg;
    logic          ev, last, smp, leave, can_load;

    always_comb begin
        ev       = (state == ST_MASTER && tick) || (state == ST_SLAVE && sck_edge && slave_sel);
        last     = (edge_cnt == CW'(EDGES - 1));
        smp      = cpha ? edge_cnt[0] : ~edge_cnt[0];
        can_load = (state != ST_MASTER) && (edge_cnt == '0) && !ev;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)                      nxt = ST_MASTER;
                       else if (slave_sel)             nxt = ST_SLAVE;
            ST_MASTER: if (abort || (ev && last))      nxt = ST_IDLE;
            ST_SLAVE:  if (!slave_sel)                 nxt = ST_IDLE;
            default:                                   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        leave  = (nxt == ST_IDLE);
        m_busy = (state == ST_MASTER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            sck_lvl  <= 1'b0;
            sreg     <= '0;
            out_bit  <= 1'b0;
            done     <= 1'b0;
            rx_data  <= '0;
        end else begin
            done <= 1'b0;
            if (ev) begin
                edge_cnt <= last ? '0 : edge_cnt + 1'b1;
                sck_lvl  <= ~sck_lvl;
                if (smp) sreg    <= {sreg[DW-2:0], din};
                else     out_bit <= sreg[DW-1];
                if (last) begin
                    done    <= 1'b1;
                    rx_data <= smp ? {sreg[DW-2:0], din} : sreg;
                end
            end
            if ((state == ST_IDLE && start) || (load && can_load)) begin
                sreg    <= load_data;
                out_bit <= load_data[DW-1];
            end
            if (leave) begin
                edge_cnt <= '0;
                sck_lvl  <= 1'b0;
            end
        end
    end

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (edge_cnt == '0 && !sck_lvl));
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_master_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MASTER && ev && last && !abort) |=> (state == ST_IDLE && done));
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i,
    output logic          irq_o,
    output logic          irq_sel_o
);
    localparam logic [AW-1:0] ADDR_DATA = AW'(0);
    localparam logic [AW-1:0] ADDR_CTRL = AW'(1);
    localparam logic [AW-1:0] ADDR_STAT = AW'(2);

    ctrl_t         ctrl;
    logic          tc, mf, tc_arm, mf_arm, tc_clr, mf_clr;
    logic          ss_s, sck_s, mosi_s, sck_q;
    logic          fault, wr_data, wr_ctrl, rd_data, rd_stat;
    logic          tick, out_bit, sck_lvl, m_busy, done;
    logic [DW-1:0] rx_data;

    spi_port_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ss_n_i, sck_i, mosi_i}),
        .q({ss_s, sck_s, mosi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    always_comb begin
        wr_data = bus_wr && (bus_addr == ADDR_DATA);
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        rd_data = bus_rd && (bus_addr == ADDR_DATA);
        rd_stat = bus_rd && (bus_addr == ADDR_STAT);
        fault   = ctrl.master && !ss_s;
        tc_clr  = tc_arm && (wr_data || rd_data);
        mf_clr  = mf_arm && wr_ctrl;
    end

    spi_port_clkgen #(.CNT_W(5)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(m_busy), .rate(ctrl.rate), .tick(tick)
    );

    spi_port_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(wr_data && ctrl.master && !m_busy && !fault),
        .load(wr_data && !ctrl.master),
        .load_data(bus_wdata[DW-1:0]),
        .abort(fault),
        .slave_sel(!ctrl.master && !ss_s),
        .cpha(ctrl.cpha),
        .tick(tick),
        .sck_edge(sck_s ^ sck_q),
        .din(ctrl.master ? miso_i : mosi_s),
        .out_bit(out_bit), .sck_lvl(sck_lvl), .m_busy(m_busy),
        .done(done), .rx_data(rx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            tc     <= 1'b0;
            mf     <= 1'b0;
            tc_arm <= 1'b0;
            mf_arm <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
            if (fault) begin
                ctrl.master <= 1'b0;
                ctrl.out_en <= 1'b0;
            end
            tc     <= done  || (tc && !tc_clr);
            mf     <= fault || (mf && !mf_clr);
            tc_arm <= tc && !tc_clr && (tc_arm || rd_stat);
            mf_arm <= mf && !mf_clr && (mf_arm || rd_stat);
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = 8'(rx_data);
            ADDR_CTRL: bus_rdata = ctrl;
            ADDR_STAT: bus_rdata = {tc, mf, 6'b0};
            default:   bus_rdata = 8'h00;
        endcase
        sck_o     = ctrl.master ? (ctrl.cpol ^ sck_lvl) : ctrl.cpol;
        sck_oe    = ctrl.out_en && ctrl.master;
        mosi_o    = out_bit;
        mosi_oe   = ctrl.out_en && ctrl.master;
        miso_o    = out_bit;
        miso_oe   = ctrl.out_en && !ctrl.master && !ss_s;
        irq_o     = ctrl.irq_en && (tc ^ mf);
        irq_sel_o = ctrl.irq_src;
    end

    assert_fault_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!ctrl.master && !ctrl.out_en && mf));
    assert_tc_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc) |-> $past(done));
    assert_mf_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf) |-> $past(fault));
endmodule

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       sck_i = 1'b0, sck_o, sck_oe;
    logic       mosi_i = 1'b0, mosi_o, mosi_oe;
    logic       miso_i, miso_o, miso_oe;
    logic       ss_n_i = 1'b1, irq_o, irq_sel_o;

    always #10 clk = ~clk;

    spi_port u_spi_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i), .irq_o(irq_o), .irq_sel_o(irq_sel_o)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: behavioural slave on the master pins
    logic [7:0] exp_q[$];
    logic       mon_on = 1'b0, mon_cpha = 1'b0, sck_prev = 1'b0;
    logic [7:0] miso_byte = '0, rx_m = '0;
    int xfer_id = 0, seen_id = 0, edge_n = 0, launches = 0, since = 0, last_half = 0, nbits = 0;

    function automatic int miso_idx(input logic ph, input int l);
        if (ph) return (l == 0) ? 7 : 8 - l;
        return (l > 7) ? 0 : 7 - l;
    endfunction
    assign miso_i = miso_byte[miso_idx(mon_cpha, launches)];

    always @(negedge clk) begin
        if (xfer_id != seen_id) begin
            seen_id = xfer_id; edge_n = 0; launches = 0; nbits = 0; since = 0; sck_prev = sck_o;
        end else if (mon_on && sck_o !== sck_prev) begin
            edge_n++; last_half = since; since = 1; sck_prev = sck_o;
            if (mon_cpha ? (edge_n % 2 == 0) : (edge_n % 2 == 1)) begin
                rx_m = {rx_m[6:0], mosi_o};
                nbits++;
                if (nbits == 8) begin
                    nbits = 0;
                    if (exp_q.size() > 0) check("R2/R3 MOSI byte", int'(rx_m), int'(exp_q.pop_front()));
                    else                  check("R5 extra byte", 1, 0);
                end
            end else begin
                launches++;
            end
        end else begin
            since++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #3 d = bus_rdata;
        step(1);
        bus_rd = 1'b0;
    endtask

    task automatic master_xfer(input logic [7:0] cw, input logic [7:0] tx, input logic [7:0] rx,
                               input int half, input logic clr, input logic poke);
        logic [7:0] v;
        reg_write(2'd1, cw);
        mon_cpha = cw[2]; miso_byte = rx; mon_on = 1'b1;
        xfer_id++;
        exp_q.push_back(tx);
        step(3);
        check("R9 master sck_oe", sck_oe, 1);
        check("R9 master mosi_oe", mosi_oe, 1);
        check("R9 master miso_oe", miso_oe, 0);
        check("R3 SCK idle before", sck_o, cw[3]);
        reg_write(2'd0, tx);
        if (poke) begin
            step(40);
            reg_write(2'd0, 8'hFF);   // R5: must be ignored
        end
        step(20 * half + 20);
        check("R2 edge count", edge_n, 16);
        check("R4 half period", last_half, half);
        check("R3 SCK idle after", sck_o, cw[3]);
        if (clr) begin
            reg_read(2'd2, v); check("R2 status complete", v, 8'h80);
            reg_read(2'd0, v); check("R2 received byte", v, rx);
            reg_read(2'd2, v); check("R11 complete cleared", v, 8'h00);
        end else begin
            reg_read(2'd0, v); check("R2 received byte", v, rx);
            reg_read(2'd2, v); check("R11 no clear without status read", v, 8'h80);
        end
    endtask

    task automatic slave_xfer(input logic [7:0] cw, input logic [7:0] tx, input logic [7:0] mo);
        localparam int H = 8;
        logic [7:0] got, v;
        ss_n_i = 1'b1; sck_i = cw[3];
        reg_write(2'd1, cw);
        reg_write(2'd0, tx);
        step(4);
        check("R7 MISO off while deselected", miso_oe, 0);
        ss_n_i = 1'b0;
        step(H);
        check("R9 slave miso_oe", miso_oe, 1);
        check("R9 slave sck_oe", sck_oe, 0);
        for (int i = 0; i < 8; i++) begin
            if (!cw[2]) begin
                mosi_i = mo[7-i]; step(H);
                got[7-i] = miso_o;
                sck_i = ~sck_i; step(H);
                sck_i = ~sck_i;
            end else begin
                sck_i = ~sck_i; mosi_i = mo[7-i]; step(H);
                got[7-i] = miso_o;
                sck_i = ~sck_i; step(H);
            end
        end
        step(H);
        ss_n_i = 1'b1;
        step(4);
        check("R6 slave MISO byte", got, tx);
        reg_read(2'd2, v); check("R6 slave complete", v, 8'h80);
        reg_read(2'd0, v); check("R6 slave received", v, mo);
        check("R7 MISO off after deselect", miso_oe, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        step(5);
        rst_n = 1'b1;
        step(2);
        reg_read(2'd1, v); check("R1 ctrl reset", v, 8'h00);
        reg_read(2'd0, v); check("R1 data reset", v, 8'h00);
        reg_read(2'd2, v); check("R1 status reset", v, 8'h00);
        check("R1 sck_o", sck_o, 0);
        check("R1 enables", {sck_oe, mosi_oe, miso_oe}, 0);
        check("R1 irq", irq_o, 0);

        master_xfer(8'h50, 8'hA5, 8'h3C, 1, 1'b1, 1'b0);
        master_xfer(8'h59, 8'h81, 8'h7E, 2, 1'b1, 1'b0);
        master_xfer(8'h56, 8'h5A, 8'hC3, 8, 1'b1, 1'b0);
        master_xfer(8'h5F, 8'hF0, 8'h0F, 16, 1'b1, 1'b1);
        master_xfer(8'hF0, 8'h96, 8'h69, 1, 1'b0, 1'b0);
        check("R10 irq on complete only", irq_o, 1);
        check("R10 source select out", irq_sel_o, 1);
        mon_on = 1'b0;

        ss_n_i = 1'b0;
        step(5);
        reg_read(2'd1, v); check("R8 ctrl after fault", v, 8'hA0);
        reg_read(2'd2, v); check("R8 status both flags", v, 8'hC0);
        check("R10 irq low with both flags", irq_o, 0);
        check("R9 enables off after fault", {sck_oe, mosi_oe, miso_oe}, 0);
        ss_n_i = 1'b1;
        step(3);
        reg_read(2'd2, v);
        reg_read(2'd0, v);
        reg_read(2'd2, v); check("R11 complete cleared, fault kept", v, 8'h40);
        check("R10 irq on fault only", irq_o, 1);
        reg_write(2'd1, 8'h00);
        reg_read(2'd2, v); check("R11 fault cleared", v, 8'h00);
        check("R10 irq low with no flags", irq_o, 0);

        slave_xfer(8'h40, 8'hB4, 8'h69);
        slave_xfer(8'h4C, 8'h2D, 8'hD2);

        ss_n_i = 1'b1; sck_i = 1'b0;
        reg_write(2'd1, 8'h40);
        for (int i = 0; i < 16; i++) begin
            sck_i = ~sck_i; step(3);
        end
        step(4);
        reg_read(2'd2, v); check("R7 SCK ignored while deselected", v, 8'h00);
        check("R7 MISO off", miso_oe, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule